// File: doc/BRIEF.md
# Segmented Physical Address Former

This unit turns a 16-bit segment value and a 16-bit offset into a 20-bit physical address. The segment value is four bits left of the offset, so one megabyte can be reached. It keeps four segment registers: code, data, stack and extra. Every request carries an access kind, and that kind picks the segment register the request uses.

Data requests may name any of the four segment registers through an override select, provided its enable is set. On instruction fetches and stack requests the override is ignored. The software that owns the segment registers loads them through a single write port. The address is registered, so it appears one cycle after the request, together with a valid strobe and the index of the segment register that was used. Any carry beyond the top address bit is dropped, so the address space wraps around.

Top module: `seg_addr_unit`

## Requirements
- R1: For each request, physAddr = (segment value × 16 + offset) mod 2^20. Segment 0xA000 with offset 0x5677 gives 0xA5677.
- R2: Two different segment/offset pairs may name the same location. Segment 0xA111 with offset 0x4567 also gives 0xA5677.
- R3: accKind encoding: 0 is an instruction fetch, 1 is a stack access, 2 and 3 are data accesses. Segment index encoding: 0 is extra, 1 is code, 2 is stack, 3 is data. Without an override, a fetch uses index 1, a stack access uses index 2 and a data access uses index 3.
- R4: When ovrEn is 1, a data access (accKind 2 or 3) uses the segment register named by ovrSel. When ovrEn is 0, ovrSel has no effect.
- R5: On fetch and stack accesses, ovrEn and ovrSel are ignored and the default segment is used.
- R6: A carry out of address bit 19 is dropped. Segment 0xFFFF with offset 0x0010 gives 0x00000, and with offset 0xFFFF gives 0x0FFEF.
- R7: A segment write with segWrEn high at one clock edge affects requests issued from the next cycle on. A request issued in the same cycle as the write still sees the old value.
- R8: addrValid is high in exactly the cycle after a cycle in which reqValid was high. physAddr and segIdx hold their values while no request arrives.
- R9: Reset is active-low and synchronous. It sets the code segment to 0xFFFF, the other three segments to 0x0000, and addrValid, physAddr and segIdx to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Synchronous reset, active low |
| reqValid | input | 1 | An address request is present |
| accKind | input | 2 | Access kind: 0 fetch, 1 stack, 2 or 3 data |
| ovrEn | input | 1 | Segment override enable, used for data accesses only |
| ovrSel | input | 2 | Segment index to use on an override |
| offset | input | 16 | Effective offset |
| segWrEn | input | 1 | Segment register write enable |
| segWrSel | input | 2 | Segment register to write |
| segWrData | input | 16 | New segment value |
| addrValid | output | 1 | A registered address is present |
| physAddr | output | 20 | 20-bit physical address |
| segIdx | output | 2 | Index of the segment register that was used |

## Verification
The situations that are hardest to reach from the ports are these: a segment write and a request that uses the same register arriving in one cycle, an override presented on a fetch or stack request, and a sum that carries past bit 19. To reach the first, the stimulus raises segWrEn and reqValid at the same clock edge. It then repeats the request one cycle later, so that the old value and the new value are both seen. The override case is reached by driving an override on every access kind. The carry case is reached by loading the code segment with its all-ones value and issuing fetches with offsets near both ends of the offset range.

// File: rtl/seg_addr_pkg.sv
package seg_addr_pkg;
  localparam int SEL_W = 2;
  localparam int NUM_SEG = 1 << SEL_W;

  typedef enum logic [1:0] {
    KIND_FETCH    = 2'd0,
    KIND_STACK    = 2'd1,
    KIND_DATA     = 2'd2,
    KIND_DATA_ALT = 2'd3
  } acc_kind_e;

  localparam logic [SEL_W-1:0] SEG_EXTRA = 2'd0;
  localparam logic [SEL_W-1:0] SEG_CODE  = 2'd1;
  localparam logic [SEL_W-1:0] SEG_STACK = 2'd2;
  localparam logic [SEL_W-1:0] SEG_DATA  = 2'd3;

  // strobes from control to datapath
  typedef struct packed {
    logic             issue;
    logic [SEL_W-1:0] readSel;
    logic             wrEn;
    logic [SEL_W-1:0] wrSel;
  } strobe_t;
endpackage

// File: rtl/seg_addr_ctrl.sv
module seg_addr_ctrl
  import seg_addr_pkg::*;
(
  input  logic             reqValid,
  input  logic [1:0]       accKind,
  input  logic             ovrEn,
  input  logic [SEL_W-1:0] ovrSel,
  input  logic             segWrEn,
  input  logic [SEL_W-1:0] segWrSel,
  output strobe_t          strb
);
  logic [SEL_W-1:0] pickSel;

  // default segment by kind; override only honoured for data (R3, R4, R5)
  always_comb begin
    case (acc_kind_e'(accKind))
      KIND_FETCH: pickSel = SEG_CODE;
      KIND_STACK: pickSel = SEG_STACK;
      default:    pickSel = ovrEn ? ovrSel : SEG_DATA;
    endcase
  end

  always_comb begin
    strb.issue   = reqValid;
    strb.readSel = pickSel;
    strb.wrEn    = segWrEn;
    strb.wrSel   = segWrSel;
  end
endmodule

// File: rtl/seg_addr_dpath.sv
module seg_addr_dpath
  import seg_addr_pkg::*;
#(
  parameter int SEG_W = 16,
  parameter int OFF_W = 16,
  parameter int SHIFT = 4,
  parameter logic [SEG_W-1:0] CODE_RST = '1
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  strobe_t                strb,
  input  logic [OFF_W-1:0]       offset,
  input  logic [SEG_W-1:0]       segWrData,
  output logic                   addrValid,
  output logic [SEG_W+SHIFT-1:0] physAddr,
  output logic [SEL_W-1:0]       segIdx
);
  localparam int ADDR_W = SEG_W + SHIFT;

  logic [SEG_W-1:0] segFile [NUM_SEG];

  for (genvar g = 0; g < NUM_SEG; g++) begin : g_seg
    localparam logic [SEG_W-1:0] RST_VAL = (g == int'(SEG_CODE)) ? CODE_RST : '0;
    logic [SEG_W-1:0] segQ;
    always_ff @(posedge clk) begin
      if (!rstN)
        segQ <= RST_VAL;
      else if (strb.wrEn && strb.wrSel == SEL_W'(g))
        segQ <= segWrData;
    end
    assign segFile[g] = segQ;
  end

  logic [SEG_W-1:0]  segSel;
  logic [ADDR_W-1:0] sumAddr;

  assign segSel  = segFile[strb.readSel];
  // truncation to ADDR_W drops the top carry (R6)
  assign sumAddr = {segSel, {SHIFT{1'b0}}} + ADDR_W'(offset);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      addrValid <= 1'b0;
      physAddr  <= '0;
      segIdx    <= '0;
    end else begin
      addrValid <= strb.issue;
      if (strb.issue) begin
        physAddr <= sumAddr;
        segIdx   <= strb.readSel;
      end
    end
  end

  // R8: valid strobe follows the request by one cycle
  a_r8_valid_follows: assert property (@(posedge clk) disable iff (!rstN)
    strb.issue |=> addrValid);
  a_r8_no_spurious: assert property (@(posedge clk) disable iff (!rstN)
    !strb.issue |=> !addrValid);
  a_r8_hold_idle: assert property (@(posedge clk) disable iff (!rstN)
    !strb.issue |=> ($stable(physAddr) && $stable(segIdx)));
  // R7: a written value is present in the register file one cycle later
  a_r7_write_lands: assert property (@(posedge clk) disable iff (!rstN)
    strb.wrEn |=> segFile[$past(strb.wrSel)] == $past(segWrData));
endmodule

// File: rtl/seg_addr_unit.sv
module seg_addr_unit
  import seg_addr_pkg::*;
#(
  parameter int SEG_W = 16,
  parameter int OFF_W = 16,
  parameter int SHIFT = 4
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  logic                   reqValid,
  input  logic [1:0]             accKind,
  input  logic                   ovrEn,
  input  logic [1:0]             ovrSel,
  input  logic [OFF_W-1:0]       offset,
  input  logic                   segWrEn,
  input  logic [1:0]             segWrSel,
  input  logic [SEG_W-1:0]       segWrData,
  output logic                   addrValid,
  output logic [SEG_W+SHIFT-1:0] physAddr,
  output logic [1:0]             segIdx
);
  strobe_t strb;

  seg_addr_ctrl i_ctrl (
    .reqValid (reqValid),
    .accKind  (accKind),
    .ovrEn    (ovrEn),
    .ovrSel   (ovrSel),
    .segWrEn  (segWrEn),
    .segWrSel (segWrSel),
    .strb     (strb)
  );

  seg_addr_dpath #(
    .SEG_W (SEG_W),
    .OFF_W (OFF_W),
    .SHIFT (SHIFT)
  ) i_dpath (
    .clk       (clk),
    .rstN      (rstN),
    .strb      (strb),
    .offset    (offset),
    .segWrData (segWrData),
    .addrValid (addrValid),
    .physAddr  (physAddr),
    .segIdx    (segIdx)
  );

  // R3: fetches land on the code segment
  a_r3_fetch_code: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && accKind == 2'd0) |=> segIdx == SEG_CODE);
  // R5: stack ignores any override
  a_r5_stack_fixed: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && accKind == 2'd1) |=> segIdx == SEG_STACK);
  // R4: data override honoured
  a_r4_data_override: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && accKind[1] && ovrEn) |=> segIdx == $past(ovrSel));
  // R3: data without override uses the data segment
  a_r3_data_default: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && accKind[1] && !ovrEn) |=> segIdx == SEG_DATA);
endmodule

// File: tb/test_seg_addr_unit.sv
`timescale 1ns/1ps
module test_seg_addr_unit;
  logic        clk = 1'b0;
  logic        rstN;
  logic        reqValid;
  logic [1:0]  accKind;
  logic        ovrEn;
  logic [1:0]  ovrSel;
  logic [15:0] offset;
  logic        segWrEn;
  logic [1:0]  segWrSel;
  logic [15:0] segWrData;
  logic        addrValid;
  logic [19:0] physAddr;
  logic [1:0]  segIdx;

  int total = 0;
  int bad = 0;

  always #4 clk = ~clk;

  seg_addr_unit i_seg_addr_unit (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .accKind(accKind),
    .ovrEn(ovrEn), .ovrSel(ovrSel), .offset(offset), .segWrEn(segWrEn),
    .segWrSel(segWrSel), .segWrData(segWrData), .addrValid(addrValid),
    .physAddr(physAddr), .segIdx(segIdx)
  );

  // {kind, ovrEn, ovrSel, offset, expAddr, expIdx}
  // segments loaded first: extra=1234 code=F000 stack=A111 data=A000
  localparam int NV = 10;
  localparam logic [42:0] VECS [NV] = '{
    {2'd2, 1'b0, 2'd0, 16'h5677, 20'hA5677, 2'd3},  // R1
    {2'd1, 1'b0, 2'd0, 16'h4567, 20'hA5677, 2'd2},  // R2
    {2'd0, 1'b0, 2'd0, 16'h0100, 20'hF0100, 2'd1},  // R3
    {2'd2, 1'b1, 2'd0, 16'h0001, 20'h12341, 2'd0},  // R4
    {2'd2, 1'b1, 2'd1, 16'h0000, 20'hF0000, 2'd1},  // R4
    {2'd3, 1'b1, 2'd2, 16'h0000, 20'hA1110, 2'd2},  // R4
    {2'd3, 1'b0, 2'd0, 16'h0010, 20'hA0010, 2'd3},  // R3
    {2'd0, 1'b1, 2'd0, 16'h0002, 20'hF0002, 2'd1},  // R5
    {2'd1, 1'b1, 2'd3, 16'h0003, 20'hA1113, 2'd2},  // R5
    {2'd2, 1'b0, 2'd0, 16'hFFFF, 20'hAFFFF, 2'd3}   // R4 select ignored
  };

  task automatic checkOut(string tag, logic expV, logic [19:0] expA, logic [1:0] expI);
    total++;
    if (addrValid !== expV || physAddr !== expA || segIdx !== expI) begin
      bad++;
      $display("FAIL %s: got valid=%0b addr=%05h idx=%0d expected valid=%0b addr=%05h idx=%0d",
               tag, addrValid, physAddr, segIdx, expV, expA, expI);
    end
  endtask

  // called at a negedge; returns at the next negedge with the result visible
  task automatic issueReq(logic [1:0] k, logic oe, logic [1:0] os, logic [15:0] off);
    reqValid = 1'b1; accKind = k; ovrEn = oe; ovrSel = os; offset = off;
    @(negedge clk);
    reqValid = 1'b0; ovrEn = 1'b0;
  endtask

  task automatic writeSeg(logic [1:0] sel, logic [15:0] val);
    segWrEn = 1'b1; segWrSel = sel; segWrData = val;
    @(negedge clk);
    segWrEn = 1'b0;
  endtask

  initial begin
    #(8 * 200000);
    bad++; total++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    rstN = 1'b0; reqValid = 1'b0; accKind = 2'd0; ovrEn = 1'b0; ovrSel = 2'd0;
    offset = 16'h0; segWrEn = 1'b0; segWrSel = 2'd0; segWrData = 16'h0;
    repeat (3) @(negedge clk);
    checkOut("R9 reset outputs", 1'b0, 20'h00000, 2'd0);
    rstN = 1'b1;
    @(negedge clk);

    // R9 reset segment values
    issueReq(2'd0, 1'b0, 2'd0, 16'h0000);
    checkOut("R9 code reset FFFF", 1'b1, 20'hFFFF0, 2'd1);
    issueReq(2'd2, 1'b0, 2'd0, 16'h1234);
    checkOut("R9 data reset 0", 1'b1, 20'h01234, 2'd3);
    issueReq(2'd1, 1'b0, 2'd0, 16'h0000);
    checkOut("R9 stack reset 0", 1'b1, 20'h00000, 2'd2);
    issueReq(2'd2, 1'b1, 2'd0, 16'h0000);
    checkOut("R9 extra reset 0", 1'b1, 20'h00000, 2'd0);

    // R8 idle cycle: valid drops, address held
    @(negedge clk);
    checkOut("R8 idle hold", 1'b0, 20'h00000, 2'd0);

    writeSeg(2'd0, 16'h1234);
    writeSeg(2'd1, 16'hF000);
    writeSeg(2'd2, 16'hA111);
    writeSeg(2'd3, 16'hA000);

    for (int i = 0; i < NV; i++) begin
      issueReq(VECS[i][42:41], VECS[i][40], VECS[i][39:38], VECS[i][37:22]);
      checkOut($sformatf("R1-table vector %0d", i), 1'b1, VECS[i][21:2], VECS[i][1:0]);
    end
    @(negedge clk);
    checkOut("R8 idle after table", 1'b0, 20'hAFFFF, 2'd3);

    // R6 wrap
    writeSeg(2'd1, 16'hFFFF);
    issueReq(2'd0, 1'b0, 2'd0, 16'h0010);
    checkOut("R6 wrap to zero", 1'b1, 20'h00000, 2'd1);
    issueReq(2'd0, 1'b0, 2'd0, 16'hFFFF);
    checkOut("R6 wrap max", 1'b1, 20'h0FFEF, 2'd1);

    // R7 same-cycle write sees old value, next cycle sees new
    segWrEn = 1'b1; segWrSel = 2'd3; segWrData = 16'h2000;
    issueReq(2'd2, 1'b0, 2'd0, 16'h0000);
    segWrEn = 1'b0;
    checkOut("R7 same cycle old", 1'b1, 20'hA0000, 2'd3);
    issueReq(2'd2, 1'b0, 2'd0, 16'h0000);
    checkOut("R7 next cycle new", 1'b1, 20'h20000, 2'd3);

    // R8 back-to-back requests keep valid high
    reqValid = 1'b1; accKind = 2'd1; offset = 16'h0001;
    @(negedge clk);
    checkOut("R8 back to back 1", 1'b1, 20'hA1111, 2'd2);
    accKind = 2'd3; offset = 16'h0002;
    @(negedge clk);
    reqValid = 1'b0;
    checkOut("R8 back to back 2", 1'b1, 20'h20002, 2'd3);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule